// File: doc/BRIEF.md
# Flash Converter Thermometer Encoder

This block sits behind the comparator bank of a flash analog-to-digital converter. A flash converter with an N-bit result has 2^N−1 comparators. Comparator k goes high when the analog input is above threshold k, so a clean input produces a thermometer pattern: every comparator from the lowest up to some level is high, and every one above that level is low. The block turns that pattern into a signed two's-complement sample and registers it on the clock.

The encoder does not count ones. Each output bit is the OR of window terms, and a window term is one comparator ANDed with the inverse of a comparator further up. Such a term is high only for the run of consecutive codes that lie between those two thresholds. With a legal pattern this gives the same result as counting ones. With an illegal pattern the block still applies the same equations, so the result is predictable. A registered flag marks any pattern with a gap, meaning a high comparator that has a low comparator somewhere below it. The default width is N=3, which gives seven comparator inputs and a result from −4 to +3.

Top module: `flash_therm_enc`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, that edge sets `code_o` to 0 and `bubble_o` to 0, whatever `cmp_i` holds.
- R2: Both outputs reflect the `cmp_i` value sampled at the previous rising edge, which is one cycle of latency. They do not change between edges.
- R3: An all-zero `cmp_i` gives `code_o` = 3'b100 (−4).
- R4: An all-ones `cmp_i` gives `code_o` = 3'b011 (+3).
- R5: A legal thermometer pattern with m low-order ones (bit index k−1 carries comparator Gk, and bits 0..m−1 are set) gives `code_o` = m − 4 in two's complement.
- R6: For every one of the 128 patterns, `code_o[2]` = NOT G4.
- R7: For every pattern, `code_o[1]` = G6 OR (G2 AND NOT G4).
- R8: For every pattern, `code_o[0]` = G7 OR (G5 AND NOT G6) OR (G3 AND NOT G4) OR (G1 AND NOT G2).
- R9: `bubble_o` is 1 exactly when some Gk is high while a lower Gj (j<k) is low. It is 0 for the eight legal patterns.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmp_i | input | 2^N−1 | Comparator outputs; bit k−1 is comparator Gk |
| code_o | output | N | Registered two's-complement result |
| bubble_o | output | 1 | Registered flag for a pattern with a gap |

## Verification
The encoder keeps no state from one sample to the next. A wrong window term therefore shows up on `code_o` one clock after the offending pattern is applied, and the next pattern clears it. The bench applies all 128 input patterns, so a term that is missing or wired to the wrong comparator gives a mismatch on at least one pattern. A damaged gap detector shows up on `bubble_o` in the same cycle. A fault in the output register shows up on the reset value or as a wrong latency.

// File: rtl/flash_enc_pkg.sv
// Shared helpers for the flash thermometer encoder.
// Assumes the code width is at least 2.
package flash_enc_pkg;
    // Number of comparator inputs for an n-bit result.
    function automatic int therm_width(input int n);
        return (1 << n) - 1;
    endfunction
endpackage

// File: rtl/therm_window_enc.sv
// Window-term encoder. Each output bit is an OR of terms of the form
// G_a AND NOT G_(a+2^b); when the upper index falls off the top of the
// comparator bank, the term is G_a alone. The result is offset binary.
// Assumes cmp_i[k-1] carries comparator Gk. Purely combinational.
module therm_window_enc
    import flash_enc_pkg::*;
#(
    parameter int N = 3
) (
    input  logic [therm_width(N)-1:0] cmp_i,
    output logic [N-1:0]              ubin_o
);
    localparam int TOP = 1 << N;

    for (genvar b = 0; b < N; b++) begin : g_bit
        localparam int STEP  = 1 << b;
        localparam int TERMS = 1 << (N - 1 - b);
        logic [TERMS-1:0] term;
        for (genvar t = 0; t < TERMS; t++) begin : g_term
            localparam int LO = (2 * t + 1) * STEP;
            localparam int HI = LO + STEP;
            if (HI >= TOP) begin : g_open
                // The window runs to the top of the bank.
                assign term[t] = cmp_i[LO-1];
            end else begin : g_closed
                // The window lies between two thresholds.
                assign term[t] = cmp_i[LO-1] & ~cmp_i[HI-1];
            end
        end
        // OR the windows that belong to this bit.
        assign ubin_o[b] = |term;
    end
endmodule

// File: rtl/therm_bubble_det.sv
// Gap detector. It flags any pair of adjacent comparators where the
// upper one is high and the lower one is low. A gap between any two
// comparators forces at least one such adjacent pair. Combinational.
module therm_bubble_det
    import flash_enc_pkg::*;
#(
    parameter int N = 3
) (
    input  logic [therm_width(N)-1:0] cmp_i,
    output logic                      bubble_o
);
    localparam int W = therm_width(N);

    logic [W-2:0] gap;
    for (genvar i = 1; i < W; i++) begin : g_pair
        // An upper comparator is high above a low neighbour.
        assign gap[i-1] = cmp_i[i] & ~cmp_i[i-1];
    end
    // Any gap flags the whole pattern.
    assign bubble_o = |gap;
endmodule

// File: rtl/flash_therm_enc.sv
// Flash converter thermometer encoder, top level. It converts the
// comparator bank to a two's-complement code by inverting the MSB of
// the offset-binary window result, flags patterns that are not a
// thermometer, and registers both. A pattern with a gap is encoded by
// the same equations. Reset is synchronous and active low.
module flash_therm_enc
    import flash_enc_pkg::*;
#(
    parameter int N = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [therm_width(N)-1:0] cmp_i,
    output logic [N-1:0]              code_o,
    output logic                      bubble_o
);
    logic [N-1:0] ubin;
    logic         bubble_c;
    logic [N-1:0] signed_c;

    therm_window_enc #(.N(N)) u_enc (
        .cmp_i  (cmp_i),
        .ubin_o (ubin)
    );

    therm_bubble_det #(.N(N)) u_bub (
        .cmp_i    (cmp_i),
        .bubble_o (bubble_c)
    );

    // Convert offset binary to two's complement by flipping the MSB.
    always_comb begin
        signed_c        = ubin;
        signed_c[N-1]   = ~ubin[N-1];
    end

    // Output register with synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_o   <= '0;
            bubble_o <= 1'b0;
        end else begin
            code_o   <= signed_c;
            bubble_o <= bubble_c;
        end
    end
endmodule

// File: rtl/flash_therm_enc_chk.sv
// Property checker for flash_therm_enc, attached through bind.
// Assumes cmp_i[k-1] carries comparator Gk.
module flash_therm_enc_chk
    import flash_enc_pkg::*;
#(
    parameter int N = 3
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [therm_width(N)-1:0] cmp_i,
    input logic [N-1:0]              code_o,
    input logic                      bubble_o
);
    localparam int W   = therm_width(N);
    localparam int MID = 1 << (N - 1);

    // R1: reset clears both outputs.
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (code_o == '0 && !bubble_o));

    // R3: all comparators low gives the most negative code.
    assert_all_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_i == '0) |=> (code_o == N'(MID)));

    // R4: all comparators high gives the most positive code.
    assert_all_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_i == '1) |=> (code_o == N'(MID - 1)));

    // R5: a legal pattern encodes to its count of ones minus the midpoint.
    assert_legal_value_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmp_i & (cmp_i + 1'b1)) == '0)
        |=> ($signed(code_o) == ($countones($past(cmp_i)) - MID)));

    // R6: the sign bit is the inverse of the middle comparator, one cycle later.
    assert_msb_R6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (code_o[N-1] == !$past(cmp_i[MID-1])));

    // R9: the flag marks exactly the patterns that are not a thermometer.
    assert_bubble_R9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (bubble_o == (($past(cmp_i) & ($past(cmp_i) + 1'b1)) != '0)));

    initial begin
        assert_width_ok: assert (W >= 3);
    end
endmodule

bind flash_therm_enc flash_therm_enc_chk #(.N(N)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmp_i    (cmp_i),
    .code_o   (code_o),
    .bubble_o (bubble_o)
);

// File: tb/flash_therm_enc_tb.sv
`timescale 1ns/1ps
module flash_therm_enc_tb;
    localparam int N = 3;
    localparam int W = 7;

    // Each entry holds {pattern[6:0], expected code[2:0]}.
    localparam logic [9:0] LEGAL_VEC [8] = '{
        {7'b0000000, 3'b100}, {7'b0000001, 3'b101},
        {7'b0000011, 3'b110}, {7'b0000111, 3'b111},
        {7'b0001111, 3'b000}, {7'b0011111, 3'b001},
        {7'b0111111, 3'b010}, {7'b1111111, 3'b011}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] cmp_i = '0;
    logic [N-1:0] code_o;
    logic         bubble_o;
    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #4 clk = ~clk;

    flash_therm_enc #(.N(N)) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmp_i    (cmp_i),
        .code_o   (code_o),
        .bubble_o (bubble_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Drive a pattern at a falling edge, then sample at the next falling edge.
    task automatic apply(input logic [W-1:0] p);
        @(negedge clk);
        cmp_i = p;
        @(negedge clk);
    endtask

    initial begin
        // R1: reset state while the inputs are nonzero.
        cmp_i = 7'b1010101;
        repeat (3) @(negedge clk);
        chk("R1 code", code_o, 0);
        chk("R1 flag", bubble_o, 0);
        rst_n = 1'b1;

        // Legal table walk (R3, R4, R5).
        foreach (LEGAL_VEC[i]) begin
            apply(LEGAL_VEC[i][9:3]);
            chk(i == 0 ? "R3" : (i == 7 ? "R4" : "R5"), code_o, LEGAL_VEC[i][2:0]);
            chk("R9 legal", bubble_o, 0);
        end

        // Exhaustive sweep of all 128 patterns (R5..R9).
        for (int p = 0; p < 128; p++) begin
            logic [7:1] g;
            logic x2, x1, x0, bub;
            int ones;
            bit legal;
            apply(p[6:0]);
            g = p[6:0];
            x2 = ~g[4];
            x1 = g[6] | (g[2] & ~g[4]);
            x0 = g[7] | (g[5] & ~g[6]) | (g[3] & ~g[4]) | (g[1] & ~g[2]);
            bub = 1'b0;
            for (int k = 2; k <= 7; k++)
                for (int j = 1; j < k; j++)
                    if (g[k] && !g[j]) bub = 1'b1;
            ones = 0;
            for (int k = 1; k <= 7; k++) ones += g[k];
            legal = (p == ((1 << ones) - 1));
            chk("R6", code_o[2], x2);
            chk("R7", code_o[1], x1);
            chk("R8", code_o[0], x0);
            chk("R9", bubble_o, bub);
            if (legal) chk("R5", $signed(code_o), ones - 4);
        end

        // R2: the output holds until the next rising edge, then updates.
        apply(7'b0000000);
        @(negedge clk);
        cmp_i = 7'b1111111;
        #1;
        chk("R2 hold", code_o, 3'b100);
        @(negedge clk);
        chk("R2 update", code_o, 3'b011);

        // R1: reset in mid-run with a gap pattern on the inputs.
        apply(7'b1011111);
        chk("R9 gap", bubble_o, 1);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 code mid-run", code_o, 0);
        chk("R1 flag mid-run", bubble_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 after reset", bubble_o, 1);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog.
    initial begin
        #(8 * 200000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule